// File: doc/BRIEF.md
# Slow-Clock Phase Tracker with Per-Phase Enables

This block runs on a fast clock that comes from the same reference as a slow clock running at one quarter of its rate. The two clocks therefore share rising edges. Logic in the fast domain often needs to know which of the four fast cycles inside the current slow cycle it is in. For example, it may have to share one external SRAM between two units that run on the slow clock. The block never treats the slow clock net as data. Instead, a register clocked by the slow clock flips on every slow rising edge. The fast domain keeps a registered copy of that register. A mismatch between the live value and the stored copy shows that the fast edge just taken coincided with a slow rising edge.

Each detected mismatch reloads a small phase counter in the fast domain. Between mismatches the counter runs freely modulo the ratio. The counter value is decoded into registered one-hot phase enables and into two time-slot selects, one for each SRAM user. All of these outputs stay low until the first slow edge after reset has been seen. A mismatch that arrives when the free-running count did not expect one sets a sticky error flag. A control input clears that flag.

Top module: `slow_phase_tracker`

## Requirements
- R1: While `rst` is high at a fast edge, `locked`, `resync_err`, `slot_a`, `slot_b` and every bit of `phase_en` read 0 after that edge, and the slow-domain toggle register returns to 0.
- R2: `locked` rises in the fast cycle that follows the first slow rising edge after reset release, and then stays high until the next reset.
- R3: Phase 0 is the fast cycle that starts on a slow rising edge. When a slow rising edge is detected, the next fast cycle shows phase 1, that is `phase_en` = 4'b0010.
- R4: While locked and between detections, exactly one bit of `phase_en` is set, and the set bit moves from p to (p+1) mod 4 on each fast cycle.
- R5: `slot_a` is high in phases 0 and 1, and `slot_b` is high in phases 2 and 3. The two are never high together.
- R6: Before `locked` rises, `phase_en`, `slot_a` and `slot_b` are all 0.
- R7: A slow period that is not a multiple of four fast cycles still realigns the phase to 1 in the fast cycle after that slow edge. Counting then resumes from there.
- R8: `resync_err` goes high with the realignment whenever a detection occurs while locked and the current count was not phase 0. It then stays high. Detections aligned with the count, including slow periods of exactly eight fast cycles, never set it.
- R9: `err_clear` high at a fast edge clears `resync_err`, unless a new misaligned detection occurs at the same edge, in which case the set wins.
- R10: The toggle register falling from 1 to 0 is treated exactly like a rise from 0 to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_fast | input | 1 | Fast clock (four times the slow rate) |
| clk_slow | input | 1 | Slow clock, edge-aligned with clk_fast |
| rst | input | 1 | Active-high synchronous reset shared by both domains |
| err_clear | input | 1 | Clears the sticky misalignment flag |
| locked | output | 1 | Phase has been acquired since reset |
| phase_en | output | 4 | One-hot enable for the current fast phase |
| slot_a | output | 1 | First SRAM time slot (phases 0 and 1) |
| slot_b | output | 1 | Second SRAM time slot (phases 2 and 3) |
| resync_err | output | 1 | Sticky: a slow edge arrived at an unexpected phase |

## Verification
The bench varies the slow period from two to eight fast cycles, one period at a time. This exposes the realignment path (R7, R8). A counter that ignores detections keeps the wrong phase. An error check that uses the count after the reload, instead of before it, flags every edge or no edge at all. The eight-cycle period is the case an over-eager error check gets wrong, because that edge lands back on phase 0. A second reset in mid-run and an `err_clear` held through a fresh error test the reset state and the set-over-clear priority. Decoding an enable from the counter's current value rather than its next value would shift every enable one cycle late against the bench's arithmetic phase model.

// File: rtl/slow_phase_pkg.sv
package slow_phase_pkg;

  // Fast cycles per slow cycle and number of SRAM time slots.
  localparam int unsigned DEF_RATIO  = 4;
  localparam int unsigned SLOT_COUNT = 2;

  // Tracking state of the phase counter.
  typedef enum logic {
    TRK_SEEK = 1'b0,
    TRK_RUN  = 1'b1
  } trk_state_e;

endpackage

// File: rtl/spt_slow_toggle.sv
// Slow-domain marker: flips on every slow rising edge.
module spt_slow_toggle (
  input  logic clk_slow,
  input  logic rst,
  output logic mark
);

  always_ff @(posedge clk_slow) begin
    if (rst) mark <= 1'b0;
    else     mark <= ~mark;
  end

endmodule

// File: rtl/spt_edge_sense.sv
// Fast-domain sampler: flags a fast edge at which the slow marker differs
// from the copy taken at the previous fast edge.
module spt_edge_sense (
  input  logic clk,
  input  logic rst,
  input  logic mark,
  output logic seen
);

  logic held_q;

  always_ff @(posedge clk) begin
    if (rst) held_q <= 1'b0;
    else     held_q <= mark;
  end

  // Either direction counts.
  assign seen = mark ^ held_q;

endmodule

// File: rtl/spt_phase_counter.sv
// Phase counter: reloads on detection, otherwise wraps modulo RATIO.
module spt_phase_counter
  import slow_phase_pkg::*;
#(
  parameter  int unsigned RATIO = DEF_RATIO,
  localparam int unsigned PH_W  = $clog2(RATIO)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            seen,
  input  logic            err_clr,
  output logic [PH_W-1:0] cnt_nx,
  output logic            lock_nx,
  output logic            locked,
  output logic            err
);

  // The detection lands one fast cycle after the slow edge.
  localparam logic [PH_W-1:0] LOAD   = PH_W'(1 % RATIO);
  localparam logic [PH_W-1:0] LAST   = PH_W'(RATIO - 1);
  localparam logic [PH_W-1:0] EXPECT = PH_W'((1 + RATIO - 1) % RATIO);

  trk_state_e      st_q, st_d;
  logic [PH_W-1:0] cnt_q;
  logic            miss;

  always_comb begin
    st_d = seen ? TRK_RUN : st_q;
    if (seen)               cnt_nx = LOAD;
    else if (cnt_q == LAST) cnt_nx = '0;
    else                    cnt_nx = cnt_q + 1'b1;
  end

  assign lock_nx = (st_d == TRK_RUN);
  assign locked  = (st_q == TRK_RUN);
  assign miss    = seen && (st_q == TRK_RUN) && (cnt_q != EXPECT);

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q  <= TRK_SEEK;
      cnt_q <= '0;
      err   <= 1'b0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_nx;
      if (miss)         err <= 1'b1;
      else if (err_clr) err <= 1'b0;
    end
  end

endmodule

// File: rtl/spt_enable_decode.sv
// Registered one-hot phase enables and slot selects, taken from the
// counter's next value so they line up with the current phase.
module spt_enable_decode
  import slow_phase_pkg::*;
#(
  parameter  int unsigned RATIO = DEF_RATIO,
  localparam int unsigned PH_W  = $clog2(RATIO),
  localparam int unsigned PER   = RATIO / SLOT_COUNT
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  lock_nx,
  input  logic [PH_W-1:0]       cnt_nx,
  output logic [RATIO-1:0]      en,
  output logic [SLOT_COUNT-1:0] slot
);

  logic [RATIO-1:0]      hit;
  logic [SLOT_COUNT-1:0] slot_hit;
  logic [PH_W:0]         cnt_w;

  assign cnt_w = {1'b0, cnt_nx};

  for (genvar p = 0; p < RATIO; p++) begin : g_phase
    assign hit[p] = (cnt_nx == PH_W'(p));
  end

  for (genvar s = 0; s < SLOT_COUNT; s++) begin : g_slot
    assign slot_hit[s] = (cnt_w >= (PH_W+1)'(s * PER)) &&
                         (cnt_w <  (PH_W+1)'((s + 1) * PER));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      en   <= '0;
      slot <= '0;
    end else begin
      en   <= lock_nx ? hit      : '0;
      slot <= lock_nx ? slot_hit : '0;
    end
  end

endmodule

// File: rtl/slow_phase_tracker.sv
module slow_phase_tracker
  import slow_phase_pkg::*;
#(
  parameter  int unsigned RATIO = DEF_RATIO,
  localparam int unsigned PH_W  = $clog2(RATIO)
) (
  input  logic             clk_fast,
  input  logic             clk_slow,
  input  logic             rst,
  input  logic             err_clear,
  output logic             locked,
  output logic [RATIO-1:0] phase_en,
  output logic             slot_a,
  output logic             slot_b,
  output logic             resync_err
);

  logic                  mark;
  logic                  seen;
  logic [PH_W-1:0]       cnt_nx;
  logic                  lock_nx;
  logic [SLOT_COUNT-1:0] slot;

  spt_slow_toggle u_tog (
    .clk_slow (clk_slow),
    .rst      (rst),
    .mark     (mark)
  );

  spt_edge_sense u_sense (
    .clk  (clk_fast),
    .rst  (rst),
    .mark (mark),
    .seen (seen)
  );

  spt_phase_counter #(.RATIO(RATIO)) u_cnt (
    .clk     (clk_fast),
    .rst     (rst),
    .seen    (seen),
    .err_clr (err_clear),
    .cnt_nx  (cnt_nx),
    .lock_nx (lock_nx),
    .locked  (locked),
    .err     (resync_err)
  );

  spt_enable_decode #(.RATIO(RATIO)) u_dec (
    .clk     (clk_fast),
    .rst     (rst),
    .lock_nx (lock_nx),
    .cnt_nx  (cnt_nx),
    .en      (phase_en),
    .slot    (slot)
  );

  assign slot_a = slot[0];
  assign slot_b = slot[1];

endmodule

// File: rtl/slow_phase_tracker_sva.sv
module slow_phase_tracker_sva #(
  parameter int unsigned RATIO = 4
) (
  input logic             clk_fast,
  input logic             rst,
  input logic             err_clear,
  input logic             locked,
  input logic [RATIO-1:0] phase_en,
  input logic             slot_a,
  input logic             slot_b,
  input logic             resync_err
);

  logic [RATIO-1:0] rot;
  assign rot = {phase_en[RATIO-2:0], phase_en[RATIO-1]};

  // R2: once locked, stays locked
  p_lock_holds_r2: assert property (@(posedge clk_fast) disable iff (rst)
    locked |=> locked);

  // R4: exactly one enable while locked
  p_one_phase_r4: assert property (@(posedge clk_fast) disable iff (rst)
    locked |-> ($countones(phase_en) == 1));

  // R4 / R3: enable rotates or is reloaded to phase 1
  p_rotate_r4: assert property (@(posedge clk_fast) disable iff (rst)
    locked |=> (phase_en == $past(rot)) || (phase_en == RATIO'(2)));

  // R6: nothing enabled before lock
  p_quiet_unlocked_r6: assert property (@(posedge clk_fast) disable iff (rst)
    !locked |-> (phase_en == '0) && !slot_a && !slot_b);

  // R5: exactly one slot while locked
  p_slot_excl_r5: assert property (@(posedge clk_fast) disable iff (rst)
    locked |-> (slot_a ^ slot_b));

  // R5: slot_a only in the lower half of the phases
  p_slot_a_r5: assert property (@(posedge clk_fast) disable iff (rst)
    slot_a |-> |phase_en[RATIO/2-1:0]);

  // R8: error only while locked, and sticky without a clear
  p_err_locked_r8: assert property (@(posedge clk_fast) disable iff (rst)
    resync_err |-> locked);

  p_err_sticky_r8: assert property (@(posedge clk_fast) disable iff (rst)
    resync_err && !err_clear |=> resync_err);

  // R7: a new error comes with the realignment to phase 1
  p_err_realign_r7: assert property (@(posedge clk_fast) disable iff (rst)
    $rose(resync_err) |-> phase_en[1]);

endmodule

bind slow_phase_tracker slow_phase_tracker_sva #(.RATIO(RATIO)) u_sva (
  .clk_fast   (clk_fast),
  .rst        (rst),
  .err_clear  (err_clear),
  .locked     (locked),
  .phase_en   (phase_en),
  .slot_a     (slot_a),
  .slot_b     (slot_b),
  .resync_err (resync_err)
);

// File: tb/slow_phase_tracker_test.sv
`timescale 1ns/1ps
module slow_phase_tracker_test;

  logic       clk_f = 1'b0;
  logic       clk_s = 1'b0;
  logic       rst = 1'b1;
  logic       err_clear = 1'b0;
  logic       locked;
  logic [3:0] phase_en;
  logic       slot_a, slot_b, resync_err;

  int n_chk = 0;
  int n_fail = 0;
  bit run = 0;
  bit done = 0;

  // slow clock shaping, in fast cycles
  int slow_len = 4;
  int next_len = 4;
  int since = 0;

  // arithmetic model of the expected outputs
  int    m_ph = 0;
  bit    m_lock = 0, m_err = 0, pending = 0, m_tog = 0, m_rst = 1, m_fall = 0;
  string m_tag = "R1";
  string e_tag = "R1";

  slow_phase_tracker uut (
    .clk_fast   (clk_f),
    .clk_slow   (clk_s),
    .rst        (rst),
    .err_clear  (err_clear),
    .locked     (locked),
    .phase_en   (phase_en),
    .slot_a     (slot_a),
    .slot_b     (slot_b),
    .resync_err (resync_err)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s at %0t: actual %0h expected %0h", tag, $time, act, exp);
    end
  endtask

  task automatic model_edge(bit rise);
    bit reload, errset, first;
    m_rst = rst;
    if (rst) begin
      m_ph = 0; m_lock = 0; m_err = 0; pending = 0; m_tog = 0;
      m_tag = "R1"; e_tag = "R1";
    end else begin
      reload = 0; errset = 0; first = 0;
      if (pending) begin
        errset = m_lock && (m_ph != 0);
        first  = !m_lock;
        m_ph   = 1;
        m_lock = 1;
        reload = 1;
      end else begin
        m_ph = (m_ph + 1) % 4;
      end
      e_tag = (err_clear && m_err) ? "R9" : "R8";
      if (err_clear) m_err = 0;
      if (errset)    m_err = 1;
      if (!m_lock)               m_tag = "R6";
      else if (first)            m_tag = "R2";
      else if (reload && errset) m_tag = "R7";
      else if (reload && m_fall) m_tag = "R10";
      else if (reload)           m_tag = "R3";
      else                       m_tag = "R4";
      pending = rise;
      if (rise) begin
        m_tog  = ~m_tog;
        m_fall = (m_tog == 0);
      end
    end
  endtask

  // both clocks generated in one process so shared edges land together
  initial begin
    forever begin
      bit rise;
      #2.5;
      clk_f = 1'b1;
      rise = 0;
      if (since == 0) begin
        clk_s = 1'b1;
        rise = 1;
      end else if (since == slow_len / 2) begin
        clk_s = 1'b0;
      end
      since++;
      if (since == slow_len) begin
        since = 0;
        slow_len = next_len;
        next_len = 4;
      end
      model_edge(rise);
      #2.5;
      clk_f = 1'b0;
    end
  end

  always @(negedge clk_f) begin
    if (run) begin
      logic [3:0] exp_en;
      exp_en = m_lock ? (4'b0001 << m_ph) : 4'b0000;
      chk(m_tag, phase_en, exp_en);
      chk(m_rst ? "R1" : "R5", {slot_a, slot_b},
          {m_lock && (m_ph < 2), m_lock && (m_ph >= 2)});
      chk(m_rst ? "R1" : "R2", locked, m_lock);
      chk(e_tag, resync_err, m_err);
    end
  end

  initial begin
    #(100000 * 5);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk_f);
    run = 1;
    repeat (8) @(posedge clk_f);
    // R1 checked during reset, then release just after a slow edge
    @(posedge clk_s);
    #1 rst = 1'b0;
    repeat (40) @(posedge clk_f);

    // sweep slow periods: R7, R8 (len 8 is aligned), R9 clears
    for (int len = 2; len <= 8; len++) begin
      next_len = len;
      repeat (24) @(posedge clk_f);
      @(negedge clk_f) err_clear = 1'b1;
      @(negedge clk_f) err_clear = 1'b0;
      repeat (12) @(posedge clk_f);
    end

    // R9: set wins over a clear held through a fresh misalignment
    @(negedge clk_f) err_clear = 1'b1;
    next_len = 5;
    repeat (14) @(posedge clk_f);
    @(negedge clk_f) err_clear = 1'b0;
    next_len = 6;
    repeat (20) @(posedge clk_f);

    // R1 again in mid-run, then reacquire (R2, R6)
    @(negedge clk_f) rst = 1'b1;
    repeat (6) @(posedge clk_f);
    @(posedge clk_s);
    #1 rst = 1'b0;
    repeat (40) @(posedge clk_f);

    done = 1;
    run = 0;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule